// File: doc/BRIEF.md
# Data Object Mailbox Controller

This block puts a request/response mailbox into a small window of configuration space. Software fills a write mailbox one DWORD at a time. A write with the Go bit set to the control register then hands the object to a protocol responder. The responder returns its reply DWORDs into a read mailbox. Software drains that reply through a single read-data register. It reads a DWORD, then writes any value to the same register to move on to the next one.

On Go, the first mailbox DWORD is compared with a parameterised table of protocol headers. The header holds the type in bits 23:16 and the vendor ID in bits 15:0. The 18-bit length field in bits 17:0 of the second DWORD must equal the number of DWORDs written. If both match, the block sends a one-cycle start pulse and the protocol index to the responder and holds Busy until the responder completes. If either fails, the object is dropped without any sign: both mailboxes empty and nothing is dispatched. The responder can finish in three ways. A good finish raises Ready. A failing finish raises Error. A silent drop does neither. A rising Ready or Error produces a one-cycle message-interrupt request, but only when interrupts are both supported and enabled.

Accesses are 1, 2 or 4 bytes wide at any byte offset of the 24-byte window. Offsets 0x00 to 0x03 belong to a capability header that this block does not implement, and they read as zero.

Top module: `dox_mailbox`

## Requirements
- R1: After reset, status (0x0C) and control (0x08) read 0, the read-data register reads 0, and the interrupt request and the dispatch start are low.
- R2: A read at 0x04 returns the interrupt-supported strap in bit 0 and the 11-bit vector in bits 11:1. A read at 0x08 returns only the interrupt-enable bit (bit 1), so Abort (bit 0) and Go (bit 31) always read 0. Offsets 0x00–0x03 and the write-data register at 0x10 read 0.
- R3: A read of size 1 or 2 bytes at byte offset k within a DWORD returns that register shifted right by 8·k bits and masked to the size. A write is shifted left by 8·k bits before it is decoded, so a one-byte write of 0x80 at 0x0B is a Go.
- R4: Each write to 0x10 appends a DWORD at the current write count. Writes beyond DEPTH DWORDs are dropped, and a Go after such an overflow is treated as a length mismatch.
- R5: A Go, accepted while neither Busy nor Ready is set, whose DWORD 0 equals protocol entry k and whose DWORD 1 bits 17:0 equal the DWORD count gives `disp_start` high for exactly the cycle after the write, with `disp_sel`=k. Status bit 0 (Busy) then reads 1 until completion. The responder reads request DWORD i on `req_word` by driving i on `req_idx`.
- R6: On a Go with an unknown header or a wrong length, nothing is dispatched, Busy and Ready stay clear, and the write count returns to zero.
- R7: A good completion sets status bit 31 (Ready) and clears Busy. A read at 0x14 then returns the pushed reply DWORDs in order. While Ready is clear it reads 0.
- R8: A write of any value to 0x14 while Ready is set advances to the next reply DWORD. After the last one, Ready clears and the mailboxes empty. Such a write while Ready is clear has no effect.
- R9: A control write with bit 0 (Abort) set clears Ready, Error and Busy, empties both mailboxes, and wins over a Go in the same write. A completion that arrives after an Abort is ignored.
- R10: A completion flagged fail sets status bit 2 (Error) and empties the mailboxes. A completion flagged drop sets neither Ready nor Error.
- R11: When Ready or Error rises while the supported strap and the enable bit are both 1, `irq_req` is high for that one cycle, `irq_vec` carries the vector, and status bit 1 sets. Status bit 1 is cleared by writing 1 to it. With the enable bit at 0 there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Register access strobe, one cycle per access |
| cfg_wr | input | 1 | 1 for a write, 0 for a read |
| cfg_off | input | 5 | Byte offset within the window |
| cfg_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| cfg_wdata | input | 32 | Write data, right-aligned |
| cfg_rdata | output | 32 | Read data, right-aligned, combinational during a read |
| int_cap | input | 1 | Strap: message interrupts supported |
| int_vec_cfg | input | 11 | Strap: interrupt message number |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | 11 | Vector for irq_req |
| disp_start | output | 1 | One-cycle dispatch pulse |
| disp_sel | output | SW | Index of the matched protocol |
| req_idx | input | AW | Request DWORD index read by the responder |
| req_word | output | 32 | Request DWORD at req_idx |
| req_len | output | LW | Number of request DWORDs |
| rsp_push | input | 1 | Responder appends rsp_word to the reply |
| rsp_word | input | 32 | Reply DWORD |
| disp_done | input | 1 | Responder completion |
| disp_drop | input | 1 | With disp_done: drop the reply silently |
| disp_fail | input | 1 | With disp_done: report Error |

## Verification
Requests are sent that differ in only one respect from a good one: a correct header with a wrong length field, an unknown header, a count past the mailbox depth, and a count exactly at the depth. These separate the header check, the length check and the overflow handling. Each of the three completion kinds is run with interrupts enabled and disabled, which separates Ready from Error and the interrupt gating from the flag setting. Sub-DWORD reads and a byte-wide Go show that the byte lanes are applied in both directions. Aborts during Busy and together with Go show the priority and that a late completion is ignored.

// File: rtl/dox_mailbox.sv
module dox_mailbox #(
  parameter int DEPTH = 64,
  parameter int NPROT = 2,
  parameter logic [NPROT*32-1:0] PROT_HDRS = {32'h0001_0001, 32'h0000_0001},
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int SW = (NPROT > 1) ? $clog2(NPROT) : 1,
  localparam int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_req,
  input  logic          cfg_wr,
  input  logic [4:0]    cfg_off,
  input  logic [2:0]    cfg_size,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          int_cap,
  input  logic [VW-1:0] int_vec_cfg,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  output logic          disp_start,
  output logic [SW-1:0] disp_sel,
  input  logic [AW-1:0] req_idx,
  output logic [31:0]   req_word,
  output logic [LW-1:0] req_len,
  input  logic          rsp_push,
  input  logic [31:0]   rsp_word,
  input  logic          disp_done,
  input  logic          disp_drop,
  input  logic          disp_fail
);

  logic [31:0]   wmb [DEPTH];
  logic [31:0]   rmb [DEPTH];
  logic [LW-1:0] wlen, rlen, ridx;
  logic          wovf, busy, ready, err, ien, ists;

  logic [2:0]  dw;
  logic [1:0]  sh;
  logic        in_win, wr;
  logic [31:0] wd;

  assign dw     = cfg_off[4:2];
  assign sh     = cfg_off[1:0];
  assign in_win = (cfg_off >= 5'd4) && (cfg_off < 5'd24);
  assign wd     = cfg_wdata << {sh, 3'b000};
  assign wr     = cfg_req && cfg_wr && in_win;

  logic wr_ctrl, wr_stat, wr_wmb, wr_rmb;
  assign wr_ctrl = wr && (dw == 3'd2);
  assign wr_stat = wr && (dw == 3'd3);
  assign wr_wmb  = wr && (dw == 3'd4);
  assign wr_rmb  = wr && (dw == 3'd5);

  logic abort_w, go_w, ien_w, go_acc;
  assign abort_w = wr_ctrl && wd[0];
  assign go_w    = wr_ctrl && !wd[0] && wd[31];
  assign ien_w   = wr_ctrl && !wd[0] && !wd[31];
  assign go_acc  = go_w && !busy && !ready;

  logic          hit;
  logic [SW-1:0] hit_idx;
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NPROT; i++) begin
      if (!hit && (wmb[0] == PROT_HDRS[i*32 +: 32])) begin
        hit     = 1'b1;
        hit_idx = SW'(i);
      end
    end
  end

  logic len_ok, go_ok, go_bad;
  assign len_ok = !wovf && (wlen >= LW'(2)) &&
                  ({{(18-LW){1'b0}}, wlen} == wmb[1][17:0]);
  assign go_ok  = go_acc && hit && len_ok;
  assign go_bad = go_acc && !(hit && len_ok);

  logic fin, fin_ok, fin_fail, fin_drop;
  assign fin      = busy && disp_done && !abort_w;
  assign fin_fail = fin && disp_fail;
  assign fin_drop = fin && !disp_fail && disp_drop;
  assign fin_ok   = fin && !disp_fail && !disp_drop;

  logic pop, last, irq_fire;
  assign pop      = wr_rmb && ready;
  assign last     = (ridx + LW'(1)) >= rlen;
  assign irq_fire = (fin_ok || fin_fail) && int_cap && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlen <= '0; rlen <= '0; ridx <= '0; wovf <= 1'b0;
      busy <= 1'b0; ready <= 1'b0; err <= 1'b0; ien <= 1'b0; ists <= 1'b0;
      disp_start <= 1'b0; disp_sel <= '0; irq_req <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        wmb[i] <= '0;
        rmb[i] <= '0;
      end
    end else begin
      disp_start <= go_ok;
      irq_req    <= irq_fire;
      if (go_ok) disp_sel <= hit_idx;
      if (irq_fire) ists <= 1'b1;
      else if (wr_stat && wd[1]) ists <= 1'b0;

      if (abort_w) begin
        busy <= 1'b0; ready <= 1'b0; err <= 1'b0;
        wlen <= '0; rlen <= '0; ridx <= '0; wovf <= 1'b0;
      end else begin
        if (ien_w) ien <= wd[1];
        if (wr_wmb && !busy && !ready) begin
          if (wlen < LW'(DEPTH)) begin
            wmb[wlen[AW-1:0]] <= wd;
            wlen <= wlen + LW'(1);
          end else begin
            wovf <= 1'b1;
          end
        end
        if (busy && rsp_push && (rlen < LW'(DEPTH))) begin
          rmb[rlen[AW-1:0]] <= rsp_word;
          rlen <= rlen + LW'(1);
        end
        if (go_ok) busy <= 1'b1;
        if (pop) ridx <= ridx + LW'(1);
        if (fin_ok) begin
          busy  <= 1'b0;
          ready <= 1'b1;
        end
        if (fin_fail) begin
          busy <= 1'b0;
          err  <= 1'b1;
        end
        if (fin_drop) busy <= 1'b0;
        if (pop && last) ready <= 1'b0;
        if (go_bad || fin_fail || fin_drop || (pop && last)) begin
          wlen <= '0; rlen <= '0; ridx <= '0; wovf <= 1'b0;
        end
      end
    end
  end

  logic [31:0] raw, mask;
  always_comb begin
    raw = '0;
    if (in_win) begin
      case (dw)
        3'd1: raw = {20'd0, int_vec_cfg, int_cap};
        3'd2: raw = {30'd0, ien, 1'b0};
        3'd3: raw = {ready, 28'd0, err, ists, busy};
        3'd5: raw = ready ? rmb[ridx[AW-1:0]] : 32'd0;
        default: raw = '0;
      endcase
    end
    case (cfg_size)
      3'd1:    mask = 32'h0000_00FF;
      3'd2:    mask = 32'h0000_FFFF;
      default: mask = 32'hFFFF_FFFF;
    endcase
  end

  assign cfg_rdata = (cfg_req && !cfg_wr) ? ((raw >> {sh, 3'b000}) & mask) : 32'd0;
  assign req_word  = wmb[req_idx];
  assign req_len   = wlen;
  assign irq_vec   = int_vec_cfg;

endmodule

// File: rtl/dox_mailbox_chk.sv
module dox_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ready,
  input logic        err,
  input logic        disp_start,
  input logic        irq_req,
  input logic        abort_w,
  input logic        go_acc,
  input logic        hit,
  input logic        cfg_req,
  input logic        cfg_wr,
  input logic [4:0]  cfg_off,
  input logic [31:0] cfg_rdata
);

  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start |=> !disp_start);

  a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start |-> busy);

  a_r7_busy_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!busy && !ready && !err));

  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (ready || err));

  a_r6_unknown_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (go_acc && !hit) |=> (!disp_start && !busy));

  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_wr && (cfg_off == 5'h14) && !ready) |-> (cfg_rdata == 32'd0));

endmodule

bind dox_mailbox dox_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready), .err(err),
  .disp_start(disp_start), .irq_req(irq_req), .abort_w(abort_w),
  .go_acc(go_acc), .hit(hit), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
  .cfg_off(cfg_off), .cfg_rdata(cfg_rdata)
);

// File: tb/dox_mailbox_bench.sv
module dox_mailbox_bench;
  localparam int DEPTH = 8;
  localparam int AW = 3;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cfg_req = 0, cfg_wr = 0;
  logic [4:0] cfg_off = 0;
  logic [2:0] cfg_size = 4;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic int_cap = 1;
  logic [10:0] int_vec_cfg = 11'h2A5;
  logic irq_req;
  logic [10:0] irq_vec;
  logic disp_start;
  logic [0:0] disp_sel;
  logic [AW-1:0] req_idx = 0;
  logic [31:0] req_word;
  logic [LW-1:0] req_len;
  logic rsp_push = 0;
  logic [31:0] rsp_word = 0;
  logic disp_done = 0, disp_drop = 0, disp_fail = 0;

  dox_mailbox #(.DEPTH(DEPTH)) u_dox_mailbox (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
    .cfg_off(cfg_off), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .int_cap(int_cap), .int_vec_cfg(int_vec_cfg),
    .irq_req(irq_req), .irq_vec(irq_vec), .disp_start(disp_start),
    .disp_sel(disp_sel), .req_idx(req_idx), .req_word(req_word),
    .req_len(req_len), .rsp_push(rsp_push), .rsp_word(rsp_word),
    .disp_done(disp_done), .disp_drop(disp_drop), .disp_fail(disp_fail)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic        wr;
    logic [4:0]  off;
    logic [2:0]  sz;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'h04, 3'd4, 32'h0, 32'h0000_054B},
    '{1'b0, 5'h05, 3'd1, 32'h0, 32'h0000_0005},
    '{1'b0, 5'h04, 3'd2, 32'h0, 32'h0000_054B},
    '{1'b0, 5'h06, 3'd2, 32'h0, 32'h0000_0000},
    '{1'b0, 5'h00, 3'd4, 32'h0, 32'h0000_0000},
    '{1'b1, 5'h08, 3'd4, 32'h0000_0002, 32'h0},
    '{1'b0, 5'h08, 3'd4, 32'h0, 32'h0000_0002},
    '{1'b0, 5'h09, 3'd1, 32'h0, 32'h0000_0000},
    '{1'b0, 5'h08, 3'd1, 32'h0, 32'h0000_0002},
    '{1'b1, 5'h08, 3'd4, 32'h7FFF_FFFE, 32'h0},
    '{1'b0, 5'h08, 3'd4, 32'h0, 32'h0000_0002},
    '{1'b0, 5'h0C, 3'd4, 32'h0, 32'h0000_0000},
    '{1'b0, 5'h14, 3'd4, 32'h0, 32'h0000_0000},
    '{1'b0, 5'h10, 3'd4, 32'h0, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] o, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_wr = 1; cfg_off = o; cfg_size = s; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 0; cfg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] o, input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    cfg_req = 1; cfg_wr = 0; cfg_off = o; cfg_size = s;
    #1 v = cfg_rdata;
    cfg_req = 0;
  endtask

  task automatic chkrd(input string tag, input logic [4:0] o, input logic [2:0] s,
                       input logic [31:0] e);
    logic [31:0] v;
    rd(o, s, v);
    chk(tag, v, e);
  endtask

  task automatic push_req(input logic [31:0] hdr, input logic [31:0] len, input int n);
    wr(5'h10, 3'd4, hdr);
    wr(5'h10, 3'd4, len);
    for (int i = 2; i < n; i++) wr(5'h10, 3'd4, 32'h100 + i);
  endtask

  task automatic respond(input int n, input logic [31:0] w0, input logic drop, input logic fail);
    for (int i = 0; i < n; i++) begin
      rsp_push = 1; rsp_word = (i == 0) ? w0 : 32'h10 * (i + 1) + 32'h2;
      @(negedge clk);
    end
    rsp_push = 0;
    disp_done = 1; disp_drop = drop; disp_fail = fail;
    @(negedge clk);
    disp_done = 0; disp_drop = 0; disp_fail = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq_req}, 32'd0);
    chk("R1 start", {31'd0, disp_start}, 32'd0);
    chkrd("R1 status", 5'h0C, 3'd4, 32'd0);
    chkrd("R1 control", 5'h08, 3'd4, 32'd0);
    chkrd("R1 rdmbox", 5'h14, 3'd4, 32'd0);

    // R2 R3 table of register vectors
    for (int k = 0; k < NV; k++) begin
      if (TBL[k].wr) wr(TBL[k].off, TBL[k].sz, TBL[k].d);
      else chkrd($sformatf("R2/R3 vec%0d", k), TBL[k].off, TBL[k].sz, TBL[k].e);
    end

    // R5 R7 R8 R11 good request to protocol 1
    push_req(32'h0001_0001, 32'd3, 3);
    wr(5'h08, 3'd4, 32'h8000_0002);
    chk("R5 start", {31'd0, disp_start}, 32'd1);
    chk("R5 sel", {31'd0, disp_sel}, 32'd1);
    req_idx = 2;
    #1 chk("R5 req_word", req_word, 32'h102);
    chkrd("R5 busy", 5'h0C, 3'd4, 32'h1);
    chk("R5 pulse", {31'd0, disp_start}, 32'd0);
    chkrd("R7 read while busy", 5'h14, 3'd4, 32'd0);
    @(negedge clk);
    respond(3, 32'hA1B2_C3D4, 0, 0);
    chk("R11 irq", {31'd0, irq_req}, 32'd1);
    chk("R11 vec", {21'd0, irq_vec}, 32'h2A5);
    @(negedge clk);
    chk("R11 one cycle", {31'd0, irq_req}, 32'd0);
    chkrd("R7 ready", 5'h0C, 3'd4, 32'h8000_0002);
    chkrd("R7 word0", 5'h14, 3'd4, 32'hA1B2_C3D4);
    chkrd("R3 byte", 5'h15, 3'd1, 32'h0000_00C3);
    chkrd("R3 half", 5'h16, 3'd2, 32'h0000_A1B2);
    wr(5'h14, 3'd4, 32'h0);
    chkrd("R8 word1", 5'h14, 3'd4, 32'h22);
    wr(5'h14, 3'd4, 32'h0);
    chkrd("R8 word2", 5'h14, 3'd4, 32'h32);
    wr(5'h14, 3'd4, 32'h0);
    chkrd("R8 ready clear", 5'h0C, 3'd4, 32'h2);
    chkrd("R8 empty", 5'h14, 3'd4, 32'd0);
    wr(5'h0C, 3'd4, 32'h2);
    chkrd("R11 w1c", 5'h0C, 3'd4, 32'd0);
    wr(5'h14, 3'd4, 32'h0); // R8 pop while not ready, checked later

    // R6 length mismatch, then mailbox reset proven by a good object
    push_req(32'h0000_0001, 32'd5, 3);
    wr(5'h08, 3'd4, 32'h8000_0002);
    chk("R6 no start", {31'd0, disp_start}, 32'd0);
    chkrd("R6 status", 5'h0C, 3'd4, 32'd0);
    push_req(32'h0000_0001, 32'd2, 2);
    wr(5'h08, 3'd4, 32'h8000_0002);
    chk("R6 reset start", {31'd0, disp_start}, 32'd1);
    chk("R6 sel0", {31'd0, disp_sel}, 32'd0);
    respond(0, 32'h0, 0, 1);
    chk("R10 fail irq", {31'd0, irq_req}, 32'd1);
    chkrd("R10 error", 5'h0C, 3'd4, 32'h6);
    chkrd("R10 no data", 5'h14, 3'd4, 32'd0);
    wr(5'h0C, 3'd4, 32'h2);
    chkrd("R10 error stays", 5'h0C, 3'd4, 32'h4);
    wr(5'h08, 3'd4, 32'h1);
    chkrd("R9 abort clears err", 5'h0C, 3'd4, 32'd0);
    chkrd("R9 ien kept", 5'h08, 3'd4, 32'h2);

    // R6 unknown header
    push_req(32'h0005_0001, 32'd2, 2);
    wr(5'h08, 3'd4, 32'h8000_0002);
    chk("R6 unknown", {31'd0, disp_start}, 32'd0);
    chkrd("R6 unknown status", 5'h0C, 3'd4, 32'd0);

    // R4 overflow, then exactly DEPTH words
    push_req(32'h0000_0001, DEPTH, DEPTH + 1);
    wr(5'h08, 3'd4, 32'h8000_0002);
    chk("R4 overflow", {31'd0, disp_start}, 32'd0);
    push_req(32'h0000_0001, DEPTH, DEPTH);
    wr(5'h08, 3'd4, 32'h8000_0002);
    chk("R4 full depth", {31'd0, disp_start}, 32'd1);
    chk("R4 len", {28'd0, req_len}, DEPTH);
    req_idx = 7;
    #1 chk("R4 last word", req_word, 32'h107);
    respond(1, 32'h9, 1, 0);
    chk("R10 drop irq", {31'd0, irq_req}, 32'd0);
    chkrd("R10 drop status", 5'h0C, 3'd4, 32'd0);

    // R9 abort while busy, then late completion ignored
    push_req(32'h0001_0001, 32'd2, 2);
    wr(5'h08, 3'd4, 32'h8000_0002);
    chk("R9 start", {31'd0, disp_start}, 32'd1);
    wr(5'h08, 3'd4, 32'h1);
    chkrd("R9 abort busy", 5'h0C, 3'd4, 32'd0);
    respond(1, 32'h7, 0, 0);
    chk("R9 late irq", {31'd0, irq_req}, 32'd0);
    chkrd("R9 late status", 5'h0C, 3'd4, 32'd0);
    push_req(32'h0001_0001, 32'd2, 2);
    wr(5'h08, 3'd4, 32'h8000_0003);
    chk("R9 abort beats go", {31'd0, disp_start}, 32'd0);
    wr(5'h08, 3'd4, 32'h8000_0000);
    chk("R9 mailbox emptied", {31'd0, disp_start}, 32'd0);

    // R11 disabled, R3 byte-wide Go, R8 earlier pop ignored
    wr(5'h08, 3'd4, 32'h0);
    chkrd("R2 ien off", 5'h08, 3'd4, 32'd0);
    push_req(32'h0001_0001, 32'd2, 2);
    wr(5'h0B, 3'd1, 32'h80);
    chk("R3 byte go", {31'd0, disp_start}, 32'd1);
    respond(1, 32'h5A, 0, 0);
    chk("R11 disabled", {31'd0, irq_req}, 32'd0);
    chkrd("R11 no ists", 5'h0C, 3'd4, 32'h8000_0000);
    chkrd("R8 idx intact", 5'h14, 3'd4, 32'h5A);
    wr(5'h14, 3'd4, 32'h0);
    chkrd("R8 done", 5'h0C, 3'd4, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule